// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block is the control datapath of one DMA channel. It produces the read (source) and write (destination) addresses for each bus transfer. It also counts transfers, issues a transfer strobe that the bus answers with a one-cycle done pulse, and raises a completion interrupt. One side of every transfer is a 24-bit memory pointer that steps after each transfer. The other side is a fixed 16-bit I/O address. A constant page byte fills the upper bits of the I/O address. A direction bit chooses which of the two is the source.

The channel has two modes. In sequential mode each accepted request moves one byte or one word, and a 16-bit counter sets how many transfers the channel performs. In block mode each accepted request moves a whole block of 1 to 256 units, back to back. At the end of each block the memory pointer returns to the value it had when that block started. The 16-bit counter then counts blocks instead of units. Software programs the channel through a simple write port and sets an enable bit to start it. The enable bit clears itself when the last transfer finishes.

Top module: `dma_seq_chan`

## Requirements
- R1: After reset, xfer_req and irq are 0, src_addr is 0x000000 and dst_addr is 0xFF0000.
- R2: Register writes use wr_sel codes 0 memory pointer, 1 I/O address, 2 count, 3 block size, 4 control and 5 interrupt clear. Control bits are: bit0 enable, bit1 block mode, bit2 direction, bit3 word size, bit4 decrement, bit5 interrupt enable. With direction 0, src_addr is the memory pointer and dst_addr is {0xFF, I/O address}. With direction 1 the two are swapped.
- R3: On each bus_done pulse while xfer_req is high, the memory pointer moves by 1 (byte) or 2 (word). It moves up, or down when the decrement bit is set, and wraps modulo 2^24.
- R4: The I/O side address is always {0xFF, I/O address} and does not change during transfers.
- R5: In sequential mode, an accepted req raises xfer_req on the next cycle. xfer_req stays high until bus_done and is low on the cycle after it, so each request gives exactly one transfer.
- R6: In sequential mode the count drops by one per transfer. The transfer that brings it to zero clears the enable bit, and later requests start nothing.
- R7: In block mode, an accepted req keeps xfer_req high for block-size transfers in a row, with a block size of 0 meaning 256. After the last transfer of the block, the memory pointer returns to its value at the start of the block.
- R8: In block mode the count drops by one per finished block. The channel completes, and the enable bit clears, when the count reaches zero.
- R9: A req that arrives while the enable bit is 0, or while a transfer is in progress, is ignored.
- R10: Completion sets a sticky flag. irq equals that flag ANDed with the interrupt-enable bit. A write with wr_sel 5 clears the flag.
- R11: xfer_word equals the word-size control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transfer request |
| bus_done | input | 1 | Bus reports the current transfer finished |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 24 | Write data |
| src_addr | output | 24 | Address read by the current transfer |
| dst_addr | output | 24 | Address written by the current transfer |
| xfer_req | output | 1 | Transfer strobe, held until bus_done |
| xfer_word | output | 1 | Transfer size: 1 word, 0 byte |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions check on every cycle that the strobe only starts after a request and is held until the bus answers. They also check that both addresses stay stable while a transfer waits (unless a register is written), that the page byte is present on one side, and that irq rises only after a bus completion or a register write. Only the bench scenarios can show the exact step sizes and directions and the restore at each block end. The same holds for the count reaching zero, the self-clearing enable, and requests being ignored while disabled or busy.

// File: rtl/dmas_pkg.sv
`timescale 1ns/1ps
package dmas_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} st_e;

  typedef struct packed {
    logic irq_en;
    logic dec;
    logic word;
    logic dir;
    logic blk;
    logic en;
  } ctl_t;

  localparam int CTL_W = 6;

  localparam logic [2:0] SEL_MEM  = 3'd0;
  localparam logic [2:0] SEL_IO   = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_BSZ  = 3'd3;
  localparam logic [2:0] SEL_CTL  = 3'd4;
  localparam logic [2:0] SEL_ICLR = 3'd5;
endpackage

// File: rtl/dmas_regs.sv
`timescale 1ns/1ps
module dmas_regs
  import dmas_pkg::*;
#(
  parameter int IOW = 16,
  parameter int BW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [2:0]     wr_sel,
  input  logic [IOW-1:0] wr_data,
  input  logic           finish,
  output ctl_t           ctl,
  output logic [IOW-1:0] io_addr,
  output logic [BW-1:0]  blk_size,
  output logic           irq_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= '0;
      io_addr  <= '0;
      blk_size <= '0;
      irq_flag <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          SEL_IO:   io_addr  <= wr_data;
          SEL_BSZ:  blk_size <= wr_data[BW-1:0];
          SEL_CTL:  ctl      <= ctl_t'(wr_data[CTL_W-1:0]);
          SEL_ICLR: irq_flag <= 1'b0;
          default: ;
        endcase
      end
      if (finish) begin
        ctl.en   <= 1'b0;
        irq_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmas_mar.sv
`timescale 1ns/1ps
module dmas_mar #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          save,
  input  logic          step,
  input  logic          restore,
  input  logic          word,
  input  logic          dec,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] start_q;
  logic [AW-1:0] amt;
  logic [AW-1:0] stepped;

  assign amt     = word ? AW'(2) : AW'(1);
  assign stepped = dec ? (addr - amt) : (addr + amt);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      start_q <= '0;
    end else begin
      if (save) start_q <= addr;
      if (ld)           addr <= ld_val;
      else if (restore) addr <= start_q;
      else if (step)    addr <= stepped;
    end
  end
endmodule

// File: rtl/dmas_count.sv
`timescale 1ns/1ps
module dmas_count #(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_cnt,
  input  logic [CW-1:0] cnt_val,
  input  logic [BW-1:0] bsz,
  input  logic          blk_mode,
  input  logic          blk_load,
  input  logic          tick,
  output logic          unit_last,
  output logic          all_last
);
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] blk_q;

  assign unit_last = blk_mode ? (blk_q == BW'(1)) : 1'b1;
  assign all_last  = (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      blk_q <= '0;
    end else begin
      if (ld_cnt)                cnt_q <= cnt_val;
      else if (tick && unit_last) cnt_q <= cnt_q - CW'(1);

      if (blk_load)  blk_q <= bsz;
      else if (tick) blk_q <= unit_last ? bsz : (blk_q - BW'(1));
    end
  end
endmodule

// File: rtl/dma_seq_chan.sv
`timescale 1ns/1ps
module dma_seq_chan
  import dmas_pkg::*;
#(
  parameter int AW = 24,
  parameter int IOW = 16,
  parameter int CW = 16,
  parameter int BW = 8,
  parameter logic [AW-IOW-1:0] IO_PAGE = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          bus_done,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          xfer_req,
  output logic          xfer_word,
  output logic          irq
);
  localparam int PW = AW - IOW;

  st_e            state;
  ctl_t           ctl;
  logic [IOW-1:0] io_addr;
  logic [BW-1:0]  blk_size;
  logic           irq_flag;
  logic [AW-1:0]  mem_addr;
  logic [AW-1:0]  io_full;
  logic           unit_last, all_last;
  logic           start, done, blk_end, finish;

  assign start   = (state == ST_IDLE) && ctl.en && req;
  assign done    = (state == ST_BUSY) && bus_done;
  assign blk_end = done && unit_last;
  assign finish  = blk_end && all_last;

  dmas_regs #(.IOW(IOW), .BW(BW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data[IOW-1:0]), .finish(finish),
    .ctl(ctl), .io_addr(io_addr), .blk_size(blk_size), .irq_flag(irq_flag)
  );

  dmas_mar #(.AW(AW)) u_mar (
    .clk(clk), .rst(rst),
    .ld(wr_en && (wr_sel == SEL_MEM)), .ld_val(wr_data),
    .save(start), .step(done), .restore(blk_end && ctl.blk),
    .word(ctl.word), .dec(ctl.dec), .addr(mem_addr)
  );

  dmas_count #(.CW(CW), .BW(BW)) u_cnt (
    .clk(clk), .rst(rst),
    .ld_cnt(wr_en && (wr_sel == SEL_CNT)), .cnt_val(wr_data[CW-1:0]),
    .bsz(blk_size), .blk_mode(ctl.blk), .blk_load(start), .tick(done),
    .unit_last(unit_last), .all_last(all_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      xfer_req <= 1'b0;
    end else if (start) begin
      state    <= ST_BUSY;
      xfer_req <= 1'b1;
    end else if (blk_end) begin
      state    <= ST_IDLE;
      xfer_req <= 1'b0;
    end
  end

  assign io_full   = {IO_PAGE, io_addr};
  assign src_addr  = ctl.dir ? io_full : mem_addr;
  assign dst_addr  = ctl.dir ? mem_addr : io_full;
  assign xfer_word = ctl.word;
  assign irq       = irq_flag && ctl.irq_en;

  generate
    if (PW < 1) begin : g_bad_width
      initial $error("address width must exceed I/O width");
    end
  endgenerate
endmodule

// File: rtl/dmas_chk.sv
`timescale 1ns/1ps
module dmas_chk #(
  parameter int AW = 24,
  parameter int IOW = 16,
  parameter logic [AW-IOW-1:0] IO_PAGE = '1
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic          bus_done,
  input logic          wr_en,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic          xfer_req,
  input logic          irq
);
  // R5
  strobe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_req) |-> $past(req));

  // R5
  strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !bus_done) |=> xfer_req);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !bus_done && !wr_en) |=> ($stable(src_addr) && $stable(dst_addr)));

  // R4
  io_page_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> ((src_addr[AW-1:IOW] == IO_PAGE) || (dst_addr[AW-1:IOW] == IO_PAGE)));

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(bus_done) || $past(wr_en)));
endmodule

bind dma_seq_chan dmas_chk #(.AW(AW), .IOW(IOW), .IO_PAGE(IO_PAGE)) u_chk (.*);

// File: tb/sim_dma_seq_chan.sv
`timescale 1ns/1ps
module sim_dma_seq_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        bus_done = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [23:0] wr_data = '0;
  logic [23:0] src_addr, dst_addr;
  logic        xfer_req, xfer_word, irq;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_seq_chan u0 (
    .clk(clk), .rst(rst), .req(req), .bus_done(bus_done),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .xfer_req(xfer_req), .xfer_word(xfer_word), .irq(irq)
  );

  // {control[7:0], memory pointer[23:0], io address[15:0], pointer after one transfer[23:0]}
  localparam logic [71:0] VEC [0:3] = '{
    {8'h01, 24'h001000, 16'h1234, 24'h001001},
    {8'h0D, 24'h00ABCE, 16'h00F0, 24'h00ABD0},
    {8'h11, 24'h000010, 16'hFFFE, 24'h00000F},
    {8'h19, 24'h000000, 16'h0001, 24'hFFFFFE}
  };

  task automatic chk(input string rq, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); bus_done = 1'b1;
    @(negedge clk); bus_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 xfer_req", {23'd0, xfer_req}, 24'd0);
    chk("R1 irq", {23'd0, irq}, 24'd0);
    chk("R1 src", src_addr, 24'h000000);
    chk("R1 dst", dst_addr, 24'hFF0000);

    // R2 R3 R5 R11 table walk, sequential single transfers
    for (int i = 0; i < 4; i++) begin
      logic [7:0]  c;
      logic [23:0] m, ma, io;
      c = VEC[i][71:64]; m = VEC[i][63:40]; io = {8'hFF, VEC[i][39:24]}; ma = VEC[i][23:0];
      wr(3'd0, m);
      wr(3'd1, {8'h00, VEC[i][39:24]});
      wr(3'd2, 24'd5);
      wr(3'd4, {16'd0, c});
      pulse_req();
      chk("R5 strobe up", {23'd0, xfer_req}, 24'd1);
      chk("R11 size", {23'd0, xfer_word}, {23'd0, c[3]});
      chk("R2 src", src_addr, c[2] ? io : m);
      chk("R2 dst", dst_addr, c[2] ? m : io);
      pulse_done();
      chk("R5 strobe down", {23'd0, xfer_req}, 24'd0);
      chk("R3 src after", src_addr, c[2] ? io : ma);
      chk("R4 dst after", dst_addr, c[2] ? ma : io);
    end

    // R9 disabled channel ignores req
    wr(3'd4, 24'h000000);
    pulse_req();
    chk("R9 disabled", {23'd0, xfer_req}, 24'd0);

    // R6 R10 sequential completion
    wr(3'd0, 24'h000200);
    wr(3'd1, 24'h000010);
    wr(3'd2, 24'd2);
    wr(3'd4, 24'h000021);
    pulse_req(); pulse_done();
    chk("R6 not yet done irq", {23'd0, irq}, 24'd0);
    pulse_req(); pulse_done();
    chk("R6 done irq", {23'd0, irq}, 24'd1);
    chk("R6 strobe low", {23'd0, xfer_req}, 24'd0);
    pulse_req();
    chk("R6 enable cleared", {23'd0, xfer_req}, 24'd0);
    chk("R6 pointer kept", src_addr, 24'h000202);
    wr(3'd5, 24'd0);
    chk("R10 cleared", {23'd0, irq}, 24'd0);

    // R10 gating by interrupt enable
    wr(3'd2, 24'd1);
    wr(3'd4, 24'h000001);
    pulse_req(); pulse_done();
    chk("R10 gated", {23'd0, irq}, 24'd0);
    wr(3'd4, 24'h000020);
    chk("R10 sticky flag shows", {23'd0, irq}, 24'd1);
    wr(3'd5, 24'd0);
    chk("R10 clear", {23'd0, irq}, 24'd0);

    // R7 R8 R9 block mode: size 3, two blocks
    wr(3'd0, 24'h000100);
    wr(3'd1, 24'h000040);
    wr(3'd3, 24'd3);
    wr(3'd2, 24'd2);
    wr(3'd4, 24'h000023);
    pulse_req();
    chk("R7 strobe", {23'd0, xfer_req}, 24'd1);
    chk("R7 first src", src_addr, 24'h000100);
    chk("R4 io dst", dst_addr, 24'hFF0040);
    pulse_req();
    pulse_done();
    chk("R7 strobe held", {23'd0, xfer_req}, 24'd1);
    chk("R7 second src", src_addr, 24'h000101);
    pulse_done();
    chk("R7 third src", src_addr, 24'h000102);
    pulse_done();
    chk("R7 block end strobe", {23'd0, xfer_req}, 24'd0);
    chk("R7 restored", src_addr, 24'h000100);
    chk("R8 first block no irq", {23'd0, irq}, 24'd0);
    chk("R9 busy req ignored", {23'd0, xfer_req}, 24'd0);
    pulse_req();
    pulse_done(); pulse_done();
    chk("R8 still busy", {23'd0, xfer_req}, 24'd1);
    pulse_done();
    chk("R8 done irq", {23'd0, irq}, 24'd1);
    chk("R8 strobe low", {23'd0, xfer_req}, 24'd0);
    pulse_req();
    chk("R8 enable cleared", {23'd0, xfer_req}, 24'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule